// File: doc/BRIEF.md
# Embedded-Clock Line Receiver with Frame Aligner

This block takes a serial line in which every data bit travels as a group of four symbols: a forced high symbol, two copies of the data bit, and a forced low symbol. Each group therefore ends low and the next one starts high, so a low-to-high step always marks a bit boundary. The receiver samples one symbol per clock. The symbol clock is assumed to run at the line rate. While it hunts, the receiver aligns its slot counter to any rising step. It declares lock once enough well-formed groups arrive in a row, and from then on it hands out one decoded bit per group.

A second stage searches the decoded bit stream for frames. Idle and stop bits are 0 and a start bit is 1. A frame is one start bit, 125 payload bits and at least four stop bits, 130 bits in all. A start bit counts only after at least four 0 bits in a row. The receiver delivers no payload until it has found a start bit. The outputs are a start-of-frame strobe, a valid/data pair for each payload bit and an end-of-frame strobe. All outputs follow the line with a fixed latency.

Top module: `ecfr_rx`

## Requirements
- R1: After reset, `locked`, `code_err`, `mid_err`, `sof`, `pld_valid` and `eof` are all 0.
- R2: While unlocked, the receiver counts well-formed groups. A well-formed group has a first symbol of 1 and a last symbol of 0. `locked` rises in the cycle after the last symbol of the 8th consecutive well-formed group is sampled. No bit is delivered for that group or for any earlier one.
- R3: When a group is malformed, `code_err` pulses high for exactly one cycle and `locked` falls in that same cycle. A malformed group has a first symbol of 0 or a last symbol of 1. After this, 8 new well-formed groups are needed to lock again.
- R4: While locked, a group whose two middle symbols differ pulses `mid_err` for one cycle. Lock is kept, and the bit value is taken from the second symbol of the group.
- R5: The bit value is the symbol that follows the forced high symbol. All outputs for a group appear in the cycle after its fourth symbol is sampled, which is a constant 4 clocks after its first symbol.
- R6: A decoded 1 that follows at least four consecutive decoded 0 bits, while no frame is open, pulses `sof` in the output cycle of that start bit.
- R7: A decoded 1 preceded by fewer than four consecutive 0 bits does not open a frame and gives no `sof` and no `pld_valid`.
- R8: After `sof`, exactly the next 125 decoded bits are delivered on `pld_valid`/`pld_data`, in order. `eof` pulses together with the 125th of them.
- R9: Inside a frame, payload 1 bits never raise `sof`. After `eof`, the stop bits count toward the run of four 0 bits that the next start bit needs.
- R10: Loss of lock inside a frame ends the frame without `eof`. After lock returns, a new run of four 0 bits is needed before any `sof`.
- R11: While unlocked, a rising step in the middle of a group moves the slot count back so that the new high symbol is slot 0. The groups that follow are then judged on that new alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one symbol per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sym_in | input | 1 | Line symbol |
| locked | output | 1 | Group alignment is locked |
| code_err | output | 1 | One-cycle pulse on a malformed group |
| mid_err | output | 1 | One-cycle pulse when the middle symbols disagree |
| sof | output | 1 | Start bit accepted |
| pld_valid | output | 1 | Payload bit strobe |
| pld_data | output | 1 | Payload bit value |
| eof | output | 1 | Strobe with the last payload bit |

## Verification
A slot counter that has slipped shows up at the ports within one group: either `code_err` pulses, or the wrong symbol is reported as data. A slipped or stuck payload counter stays hidden for up to one frame. It then appears as an `eof` in the wrong place, or as payload strobes after the frame should have closed. The scoreboard catches both, because every `sof`, payload bit and `eof` must match a queued expectation in order, and any leftover or unexpected item is reported. A wrong zero-run count shows up as an `sof` that is missing or extra on the very bit that starts the frame.

// File: rtl/ecfr_pkg.sv
package ecfr_pkg;

    localparam int unsigned GROUP_SLOTS = 4;

    // Slot index of the most recently sampled symbol inside a group
    typedef enum logic [1:0] {
        SLOT_HI  = 2'd0,
        SLOT_DA  = 2'd1,
        SLOT_DB  = 2'd2,
        SLOT_LO  = 2'd3
    } slot_e;

    // One decoded bit handed from the group decoder to the aligner
    typedef struct packed {
        logic vld;
        logic data;
        logic mid_bad;
    } dbit_t;

    typedef enum logic {
        FR_HUNT = 1'b0,
        FR_BODY = 1'b1
    } frm_e;

    // Both fixed marks of a group are present
    function automatic logic marks_ok(input logic first_sym, input logic last_sym);
        return first_sym & ~last_sym;
    endfunction

endpackage

// File: rtl/ecfr_group_decoder.sv
module ecfr_group_decoder
    import ecfr_pkg::*;
#(
    parameter int unsigned LOCK_GROUPS = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sym_in,
    output dbit_t bit_o,
    output logic  locked_o,
    output logic  code_err_o
);

    localparam int unsigned CW = $clog2(LOCK_GROUPS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(LOCK_GROUPS - 1);

    logic          prev_sym;
    logic          aligned;
    slot_e         slot;
    logic          hi_q;
    logic          da_q;
    logic          db_q;
    logic [CW-1:0] good_cnt;
    logic          rise;

    assign rise = ~prev_sym & sym_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sym   <= 1'b1;
            aligned    <= 1'b0;
            slot       <= SLOT_LO;
            hi_q       <= 1'b0;
            da_q       <= 1'b0;
            db_q       <= 1'b0;
            good_cnt   <= '0;
            locked_o   <= 1'b0;
            code_err_o <= 1'b0;
            bit_o      <= '0;
        end else begin
            prev_sym   <= sym_in;
            code_err_o <= 1'b0;
            bit_o      <= '0;
            if (!locked_o && rise) begin
                // hunting: any rising step is taken as slot 0
                slot    <= SLOT_HI;
                hi_q    <= sym_in;
                aligned <= 1'b1;
                if (aligned && slot != SLOT_LO) begin
                    good_cnt <= '0;
                end
            end else if (aligned) begin
                unique case (slot)
                    SLOT_LO: begin
                        slot <= SLOT_HI;
                        hi_q <= sym_in;
                    end
                    SLOT_HI: begin
                        slot <= SLOT_DA;
                        da_q <= sym_in;
                    end
                    SLOT_DA: begin
                        slot <= SLOT_DB;
                        db_q <= sym_in;
                    end
                    SLOT_DB: begin
                        slot <= SLOT_LO;
                        if (marks_ok(hi_q, sym_in)) begin
                            if (locked_o) begin
                                bit_o.vld     <= 1'b1;
                                bit_o.data    <= da_q;
                                bit_o.mid_bad <= da_q ^ db_q;
                            end else if (good_cnt == CNT_LAST) begin
                                locked_o <= 1'b1;
                                good_cnt <= '0;
                            end else begin
                                good_cnt <= good_cnt + 1'b1;
                            end
                        end else begin
                            code_err_o <= 1'b1;
                            locked_o   <= 1'b0;
                            aligned    <= 1'b0;
                            good_cnt   <= '0;
                        end
                    end
                    default: slot <= SLOT_LO;
                endcase
            end
        end
    end

    // R3: a framing error never coexists with lock
    p_err_drops_lock_r3: assert property (@(posedge clk) disable iff (rst)
        code_err_o |-> !locked_o);

    // R3: the error flag is a single-cycle pulse
    p_err_single_r3: assert property (@(posedge clk) disable iff (rst)
        code_err_o |=> !code_err_o);

    // R2: bits only leave while lock was already held
    p_bits_need_lock_r2: assert property (@(posedge clk) disable iff (rst)
        bit_o.vld |-> $past(locked_o));

    // R2: the group that completes lock delivers no bit
    p_lock_group_silent_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> !bit_o.vld);

    // R5: at most one bit per group, never on consecutive cycles
    p_bit_spacing_r5: assert property (@(posedge clk) disable iff (rst)
        bit_o.vld |=> !bit_o.vld);

endmodule

// File: rtl/ecfr_frame_aligner.sv
module ecfr_frame_aligner
    import ecfr_pkg::*;
#(
    parameter int unsigned PAYLOAD_BITS = 125,
    parameter int unsigned MIN_ZEROS    = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  locked_i,
    input  dbit_t bit_i,
    output logic  sof_o,
    output logic  pld_valid_o,
    output logic  pld_data_o,
    output logic  eof_o
);

    localparam int unsigned ZW = $clog2(MIN_ZEROS + 1);
    localparam int unsigned PW = $clog2(PAYLOAD_BITS + 1);
    localparam logic [ZW-1:0] ZRUN_FULL = ZW'(MIN_ZEROS);
    localparam logic [PW-1:0] PCNT_LAST = PW'(PAYLOAD_BITS - 1);

    frm_e          state;
    logic [ZW-1:0] zrun;
    logic [PW-1:0] pcnt;
    logic          start_ok;

    assign start_ok    = bit_i.vld & bit_i.data & (state == FR_HUNT) & (zrun == ZRUN_FULL);
    assign sof_o       = start_ok;
    assign pld_valid_o = bit_i.vld & (state == FR_BODY);
    assign pld_data_o  = bit_i.data;
    assign eof_o       = pld_valid_o & (pcnt == PCNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || !locked_i) begin
            state <= FR_HUNT;
            zrun  <= '0;
            pcnt  <= '0;
        end else if (bit_i.vld) begin
            unique case (state)
                FR_HUNT: begin
                    if (start_ok) begin
                        state <= FR_BODY;
                        pcnt  <= '0;
                    end else if (bit_i.data) begin
                        zrun <= '0;
                    end else if (zrun != ZRUN_FULL) begin
                        zrun <= zrun + 1'b1;
                    end
                end
                FR_BODY: begin
                    if (pcnt == PCNT_LAST) begin
                        state <= FR_HUNT;
                        zrun  <= '0;
                        pcnt  <= '0;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                default: state <= FR_HUNT;
            endcase
        end
    end

    // R6: a start bit is never also a payload bit
    p_sof_not_payload_r6: assert property (@(posedge clk) disable iff (rst)
        sof_o |-> !pld_valid_o);

    // R8: end of frame rides on a payload strobe
    p_eof_on_payload_r8: assert property (@(posedge clk) disable iff (rst)
        eof_o |-> pld_valid_o);

    // R8: payload index stays inside the frame
    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        pcnt < PW'(PAYLOAD_BITS));

    // R9: after the last payload bit the aligner hunts again
    p_eof_then_hunt_r9: assert property (@(posedge clk) disable iff (rst)
        eof_o |=> state == FR_HUNT);

    // R10: an open frame requires lock on the previous cycle
    p_body_needs_lock_r10: assert property (@(posedge clk) disable iff (rst)
        (state == FR_BODY) |-> $past(locked_i));

endmodule

// File: rtl/ecfr_rx.sv
module ecfr_rx
    import ecfr_pkg::*;
#(
    parameter int unsigned LOCK_GROUPS  = 8,
    parameter int unsigned PAYLOAD_BITS = 125,
    parameter int unsigned MIN_ZEROS    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sym_in,
    output logic locked,
    output logic code_err,
    output logic mid_err,
    output logic sof,
    output logic pld_valid,
    output logic pld_data,
    output logic eof
);

    dbit_t dbit;

    ecfr_group_decoder #(
        .LOCK_GROUPS(LOCK_GROUPS)
    ) u_dec (
        .clk        (clk),
        .rst        (rst),
        .sym_in     (sym_in),
        .bit_o      (dbit),
        .locked_o   (locked),
        .code_err_o (code_err)
    );

    ecfr_frame_aligner #(
        .PAYLOAD_BITS(PAYLOAD_BITS),
        .MIN_ZEROS   (MIN_ZEROS)
    ) u_frm (
        .clk         (clk),
        .rst         (rst),
        .locked_i    (locked),
        .bit_i       (dbit),
        .sof_o       (sof),
        .pld_valid_o (pld_valid),
        .pld_data_o  (pld_data),
        .eof_o       (eof)
    );

    assign mid_err = dbit.vld & dbit.mid_bad;

    // R4: a middle-symbol mismatch is reported only with lock held
    p_mid_needs_lock_r4: assert property (@(posedge clk) disable iff (rst)
        mid_err |-> locked);

endmodule

// File: tb/ecfr_rx_tb.sv
module ecfr_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PAYLOAD    = 125;

    localparam int K_SOF = 0;
    localparam int K_PLD = 1;
    localparam int K_EOF = 2;

    typedef struct {
        int   kind;
        logic d;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_in = 1'b0;
    logic locked, code_err, mid_err, sof, pld_valid, pld_data, eof;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecfr_rx u_dut (
        .clk       (clk),
        .rst       (rst),
        .sym_in    (sym_in),
        .locked    (locked),
        .code_err  (code_err),
        .mid_err   (mid_err),
        .sof       (sof),
        .pld_valid (pld_valid),
        .pld_data  (pld_data),
        .eof       (eof)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic d);
        exp_t e;
        e.kind = kind;
        e.d    = d;
        exp_q.push_back(e);
    endtask

    task automatic send_sym(input logic s);
        @(negedge clk);
        sym_in = s;
    endtask

    task automatic send_raw(input logic a, input logic b, input logic c, input logic d);
        send_sym(a); send_sym(b); send_sym(c); send_sym(d);
    endtask

    task automatic send_group(input logic b);
        send_raw(1'b1, b, b, 1'b0);
    endtask

    // sample just after the edge that took the last driven symbol
    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    function automatic logic pat(input int frame, input int i);
        return logic'(((i * 5 + frame * 3) % 7) < 3);
    endfunction

    // payload bits of one frame, each expected on the scoreboard
    task automatic send_payload(input int frame, input int count, input bit with_eof);
        for (int i = 0; i < count; i++) begin
            logic b;
            b = pat(frame, i);
            push(K_PLD, b);
            if (with_eof && i == count - 1) push(K_EOF, 1'b0);
            send_group(b);
        end
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_group(1'b0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sof) begin
                if (exp_q.size() == 0 || exp_q[0].kind != K_SOF) begin
                    check(1'b0, "R6 unexpected sof", 1, 0);
                end else begin
                    void'(exp_q.pop_front());
                    check(1'b1, "R6 sof", 1, 1);
                end
            end
            if (pld_valid) begin
                if (exp_q.size() == 0 || exp_q[0].kind != K_PLD) begin
                    check(1'b0, "R8 unexpected payload bit", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(pld_data == e.d, "R8 payload data", int'(pld_data), int'(e.d));
                end
            end
            if (eof) begin
                if (exp_q.size() == 0 || exp_q[0].kind != K_EOF) begin
                    check(1'b0, "R8 unexpected eof", 1, 0);
                end else begin
                    void'(exp_q.pop_front());
                    check(1'b1, "R8 eof", 1, 1);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check({locked, code_err, mid_err, sof, pld_valid, eof} == 6'b0, "R1 reset outputs",
              int'({locked, code_err, mid_err, sof, pld_valid, eof}), 0);
        @(negedge clk);
        rst = 1'b0;

        // idle low, then a mid-group rising step to realign on (R11)
        send_sym(1'b0); send_sym(1'b0);
        send_sym(1'b1); send_sym(1'b0);
        for (int g = 0; g < 7; g++) send_group(logic'(g % 2));
        after_edge();
        check(locked == 1'b0, "R2 not locked after 7 groups", int'(locked), 0);
        check(code_err == 1'b0, "R11 realign without error", int'(code_err), 0);
        send_group(1'b1);
        after_edge();
        check(locked == 1'b1, "R2 locked after 8 groups", int'(locked), 1);

        // R7: a 1 after only 3 zeros opens nothing
        send_zeros(3);
        send_group(1'b1);
        after_edge();
        check(sof == 1'b0, "R7 no sof after short run", int'(sof), 0);

        // frame 1
        send_zeros(4);
        push(K_SOF, 1'b0);
        send_group(1'b1);
        after_edge();
        check(sof == 1'b1, "R5 R6 sof timing", int'(sof), 1);
        send_payload(1, PAYLOAD, 1'b1);

        // R9: four stop bits then an immediate start bit
        send_zeros(4);
        push(K_SOF, 1'b0);
        send_group(1'b1);
        // frame 2 with a middle-symbol mismatch at payload bit 10
        for (int i = 0; i < PAYLOAD; i++) begin
            logic b;
            b = pat(2, i);
            push(K_PLD, b);
            if (i == PAYLOAD - 1) push(K_EOF, 1'b0);
            if (i == 10) begin
                send_raw(1'b1, b, ~b, 1'b0);
                after_edge();
                check(mid_err == 1'b1, "R4 mid_err pulse", int'(mid_err), 1);
                check(locked == 1'b1, "R4 lock kept", int'(locked), 1);
            end else begin
                send_group(b);
            end
        end

        // R7: three stop bits then a 1: ignored
        send_zeros(3);
        send_group(1'b1);
        // frame 3, aborted by a framing error
        send_zeros(4);
        push(K_SOF, 1'b0);
        send_group(1'b1);
        send_payload(3, 40, 1'b0);
        send_raw(1'b1, 1'b0, 1'b0, 1'b1);
        after_edge();
        check(code_err == 1'b1, "R3 code_err on high last symbol", int'(code_err), 1);
        check(locked == 1'b0, "R3 lock dropped", int'(locked), 0);
        send_sym(1'b0);
        after_edge();
        check(code_err == 1'b0, "R3 code_err single pulse", int'(code_err), 0);

        // R3: relock needs 8 fresh groups
        send_zeros(7);
        after_edge();
        check(locked == 1'b0, "R3 no relock after 7", int'(locked), 0);
        send_group(1'b0);
        after_edge();
        check(locked == 1'b1, "R3 relock after 8", int'(locked), 1);

        // R10: a 1 right after relock does not start a frame
        send_group(1'b1);
        after_edge();
        check(sof == 1'b0, "R10 no sof right after relock", int'(sof), 0);
        send_zeros(4);
        push(K_SOF, 1'b0);
        send_group(1'b1);
        send_payload(4, PAYLOAD, 1'b1);

        // R3: first symbol low while locked
        send_zeros(2);
        send_raw(1'b0, 1'b1, 1'b1, 1'b0);
        after_edge();
        check(code_err == 1'b1, "R3 code_err on low first symbol", int'(code_err), 1);
        check(locked == 1'b0, "R3 lock dropped again", int'(locked), 0);

        send_sym(1'b0);
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R8 R10 all expected items seen", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule